// File: doc/BRIEF.md
# Programmable Halfband Decimator

The block filters a stream of signed samples with a halfband low-pass response and halves the sample rate. Each incoming sample arrives with a one-cycle valid pulse. Samples go alternately into an even delay line and an odd delay line. Storing an odd-position sample starts one run of a short phase sequence. In every active phase, one shared pre-adder, one multiplier and one accumulator do the work. After the final phase, one rounded and saturated result leaves with a one-cycle valid pulse.

The schedule is not fixed in logic. A small control table, loaded at run time, gives each phase its delay-line read addresses, its coefficient slot and its accumulator actions. Both the coefficients and the table are filled through a register-write port. In the filter, the odd taps are symmetric: each phase adds two odd-line samples whose addresses mirror each other, and multiplies the sum by one coefficient. The centre tap is read from the even line and enters at a fixed weight of one half.

Top module: `hb_decim_core`

## Requirements
- R1: Reset clears both delay lines, the accumulator and the phase counter, and drives smp_o to 0 and smp_vld_o low. A result computed after reset includes only samples stored since reset.
- R2: A write to register 124 stores the low 18 bits of the data, as a signed value, into the next coefficient slot. Slots are filled 0,1,…,7 and the pointer then wraps to slot 0. Upper data bits have no effect.
- R3: A write to register 125 stores bits 19:0 into the next control entry. Entries are filled from 8 down to 0 and the pointer then wraps to 8. Entry layout: bit 19 output strobe, bit 18 accumulate, bit 17 load, bit 16 done, 15:12 even address, 11:8 odd address A, 7:4 odd address B, 3:0 coefficient slot.
- R4: After reset the first accepted sample goes to the even line, the next to the odd line, and so on alternately. A line stores a new sample at address 0 and moves older samples up one address, so address 15 holds the oldest. Storing an odd sample starts the sequence at phase 1 on the next cycle.
- R5: A load phase sets the accumulator to (odd[A]+odd[B])·coef + even[E]·2^15. An accumulate phase adds (odd[A]+odd[B])·coef to the accumulator. A phase with neither flag leaves the accumulator unchanged.
- R6: The result is (acc + 2^15) shifted arithmetically right by 16, saturated to the range −131072…131071.
- R7: The phase flagged done ends the run. When that phase also carries the output strobe, smp_o updates and smp_vld_o pulses for one cycle. With the nine-entry schedule, this happens 8 clocks after the edge that stored the odd sample.
- R8: When an odd sample is stored in the same cycle as the done phase, the new run starts at phase 1 and the finishing result is still emitted. Inputs spaced 4 clocks apart therefore give one correct result per input pair.
- R9: Register writes to any address other than 124 and 125 change neither coefficients nor control entries.
- R10: Between runs the sequencer rests at phase 0 and produces no output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register write address |
| cfg_data_i | input | 32 | Register write data |
| smp_i | input | 17 | Signed input sample |
| smp_vld_i | input | 1 | Input sample valid |
| smp_o | output | 18 | Signed filtered output sample |
| smp_vld_o | output | 1 | Output sample valid |

## Verification
Two functions can fall in the same cycle: the done phase that emits a result, and the storing of the next odd sample that restarts the sequencer. The bench provokes this by feeding samples exactly 4 clocks apart, so every trigger lands on a done cycle. It judges the overlap by checking that each result arrives at its predicted cycle and matches an arithmetic model of the requirements. A second pass with wider spacing covers the sequencer resting idle between runs.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned HBD_AW    = 4;
  localparam int unsigned HBD_DEPTH = 1 << HBD_AW;

  // packed MSB first: strobe, accumulate, load, done, even, odd A, odd B, coef
  typedef struct packed {
    logic              out_stb;
    logic              acc_en;
    logic              acc_ld;
    logic              done;
    logic [HBD_AW-1:0] ev_addr;
    logic [HBD_AW-1:0] oa_addr;
    logic [HBD_AW-1:0] ob_addr;
    logic [HBD_AW-1:0] cf_addr;
  } hbd_ctrl_t;

  localparam int unsigned HBD_CTRL_W = $bits(hbd_ctrl_t);
endpackage

// File: rtl/hbd_delay.sv
module hbd_delay #(
  parameter int unsigned W   = 17,
  parameter int unsigned NRD = 2
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        wr_i,
  input  logic [W-1:0]                                din_i,
  input  logic [NRD-1:0][hbd_pkg::HBD_AW-1:0]         rd_addr_i,
  output logic [NRD-1:0][W-1:0]                       rd_data_o
);
  localparam int unsigned DEPTH = hbd_pkg::HBD_DEPTH;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) mem_q[i] <= mem_q[i-1];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end

  p_newest_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[0] == $past(din_i));
  p_hold_when_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mem_q[DEPTH-1]));
endmodule

// File: rtl/hbd_cfg.sv
module hbd_cfg #(
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned CFG_DW   = 32,
  parameter int unsigned COEF_W   = 18,
  parameter int unsigned NCOEF    = 8,
  parameter int unsigned NPH      = 9,
  parameter int unsigned COEF_REG = 124,
  parameter int unsigned CTRL_REG = 125,
  localparam int unsigned CIW     = $clog2(NCOEF),
  localparam int unsigned PW      = $clog2(NPH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CFG_AW-1:0]        addr_i,
  input  logic [CFG_DW-1:0]        data_i,
  input  logic [PW-1:0]            phase_i,
  input  logic [hbd_pkg::HBD_AW-1:0] cf_sel_i,
  output hbd_pkg::hbd_ctrl_t       ctrl_o,
  output logic signed [COEF_W-1:0] coef_o
);
  import hbd_pkg::*;

  logic signed [COEF_W-1:0] coef_q [NCOEF];
  hbd_ctrl_t                ctrl_q [NPH];
  logic [CIW-1:0]           cptr_q;
  logic [PW-1:0]            tptr_q;

  logic wr_coef, wr_ctrl;
  assign wr_coef = we_i && (addr_i == CFG_AW'(COEF_REG));
  assign wr_ctrl = we_i && (addr_i == CFG_AW'(CTRL_REG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cptr_q <= '0;
      tptr_q <= PW'(NPH-1);
    end else begin
      if (wr_coef) cptr_q <= (cptr_q == CIW'(NCOEF-1)) ? '0 : cptr_q + 1'b1;
      if (wr_ctrl) tptr_q <= (tptr_q == '0) ? PW'(NPH-1) : tptr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_coef) coef_q[cptr_q] <= data_i[COEF_W-1:0];
    if (wr_ctrl) ctrl_q[tptr_q] <= data_i[HBD_CTRL_W-1:0];
  end

  assign coef_o = (cf_sel_i < NCOEF) ? coef_q[cf_sel_i[CIW-1:0]] : '0;
  assign ctrl_o = (phase_i < NPH) ? ctrl_q[phase_i] : '0;

  p_table_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && tptr_q == '0) |=> tptr_q == PW'(NPH-1));
  p_coef_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_coef && cptr_q == CIW'(NCOEF-1)) |=> cptr_q == '0);
  p_other_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_coef && !wr_ctrl) |=> ($stable(cptr_q) && $stable(tptr_q)));
endmodule

// File: rtl/hbd_mac.sv
module hbd_mac #(
  parameter int unsigned SMP_W     = 17,
  parameter int unsigned COEF_W    = 18,
  parameter int unsigned TAP_W     = 20,
  parameter int unsigned ACC_W     = 40,
  parameter int unsigned OUT_W     = 18,
  parameter int unsigned CTR_SHIFT = 15,
  parameter int unsigned OUT_SHIFT = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     active_i,
  input  logic                     ld_i,
  input  logic                     acc_i,
  input  logic                     done_i,
  input  logic                     stb_i,
  input  logic signed [SMP_W-1:0]  odd_a_i,
  input  logic signed [SMP_W-1:0]  odd_b_i,
  input  logic signed [SMP_W-1:0]  ctr_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [OUT_W-1:0]  smp_o,
  output logic                     smp_vld_o
);
  localparam logic signed [ACC_W-1:0] RND_K = ACC_W'(1) << (OUT_SHIFT-1);
  localparam logic signed [ACC_W-1:0] S_MAX = (ACC_W'(1) << (OUT_W-1)) - 1;
  localparam logic signed [ACC_W-1:0] S_MIN = -S_MAX - 1;

  logic signed [TAP_W-1:0]  pre;
  logic signed [ACC_W-1:0]  prod, ctr_w, acc_q, acc_nxt, rnd, scl;
  logic signed [OUT_W-1:0]  sat;

  assign pre   = TAP_W'(odd_a_i) + TAP_W'(odd_b_i);
  assign prod  = ACC_W'(pre) * ACC_W'(coef_i);
  assign ctr_w = ACC_W'(ctr_i) <<< CTR_SHIFT;

  always_comb begin
    acc_nxt = acc_q;
    if (ld_i)       acc_nxt = prod + ctr_w;
    else if (acc_i) acc_nxt = acc_q + prod;
  end

  assign rnd = acc_nxt + RND_K;
  assign scl = rnd >>> OUT_SHIFT;

  always_comb begin
    if (scl > S_MAX)      sat = S_MAX[OUT_W-1:0];
    else if (scl < S_MIN) sat = S_MIN[OUT_W-1:0];
    else                  sat = scl[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      smp_o     <= '0;
      smp_vld_o <= 1'b0;
    end else begin
      smp_vld_o <= active_i && done_i && stb_i;
      if (active_i) acc_q <= acc_nxt;
      if (active_i && done_i && stb_i) smp_o <= sat;
    end
  end

  p_acc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(acc_q));
  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_o |-> $stable(smp_o) || $past(active_i && done_i && stb_i));
endmodule

// File: rtl/hb_decim_core.sv
module hb_decim_core #(
  parameter int unsigned SMP_W     = 17,
  parameter int unsigned COEF_W    = 18,
  parameter int unsigned TAP_W     = 20,
  parameter int unsigned ACC_W     = 40,
  parameter int unsigned OUT_W     = 18,
  parameter int unsigned NCOEF     = 8,
  parameter int unsigned NPH       = 9,
  parameter int unsigned CFG_AW    = 8,
  parameter int unsigned CFG_DW    = 32,
  parameter int unsigned COEF_REG  = 124,
  parameter int unsigned CTRL_REG  = 125,
  parameter int unsigned CTR_SHIFT = 15,
  parameter int unsigned OUT_SHIFT = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [CFG_DW-1:0]       cfg_data_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    smp_vld_i,
  output logic signed [OUT_W-1:0] smp_o,
  output logic                    smp_vld_o
);
  import hbd_pkg::*;
  localparam int unsigned PW = $clog2(NPH);

  logic [PW-1:0]            phase_q;
  logic                     odd_q, trig, active;
  hbd_ctrl_t                ctl;
  logic signed [COEF_W-1:0] coef;
  logic [0:0][SMP_W-1:0]    ev_rd;
  logic [1:0][SMP_W-1:0]    od_rd;

  assign trig   = smp_vld_i && odd_q;
  assign active = (phase_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      if (smp_vld_i) odd_q <= ~odd_q;
      if (trig)
        phase_q <= PW'(1);
      else if (active)
        phase_q <= (ctl.done || phase_q == PW'(NPH-1)) ? '0 : phase_q + 1'b1;
    end
  end

  hbd_cfg #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .COEF_W(COEF_W), .NCOEF(NCOEF),
    .NPH(NPH), .COEF_REG(COEF_REG), .CTRL_REG(CTRL_REG)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .data_i(cfg_data_i), .phase_i(phase_q), .cf_sel_i(ctl.cf_addr),
    .ctrl_o(ctl), .coef_o(coef)
  );

  hbd_delay #(.W(SMP_W), .NRD(1)) i_even (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(smp_vld_i && !odd_q), .din_i(smp_i),
    .rd_addr_i(ctl.ev_addr), .rd_data_o(ev_rd)
  );

  hbd_delay #(.W(SMP_W), .NRD(2)) i_odd (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(trig), .din_i(smp_i),
    .rd_addr_i({ctl.ob_addr, ctl.oa_addr}), .rd_data_o(od_rd)
  );

  hbd_mac #(
    .SMP_W(SMP_W), .COEF_W(COEF_W), .TAP_W(TAP_W), .ACC_W(ACC_W),
    .OUT_W(OUT_W), .CTR_SHIFT(CTR_SHIFT), .OUT_SHIFT(OUT_SHIFT)
  ) i_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active),
    .ld_i(ctl.acc_ld), .acc_i(ctl.acc_en), .done_i(ctl.done), .stb_i(ctl.out_stb),
    .odd_a_i(od_rd[0]), .odd_b_i(od_rd[1]), .ctr_i(ev_rd[0]), .coef_i(coef),
    .smp_o(smp_o), .smp_vld_o(smp_vld_o)
  );

  p_start_phase1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> phase_q == PW'(1));
  p_done_to_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ctl.done && !trig) |=> phase_q == '0);
  p_restart_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ctl.done && trig) |=> (phase_q == PW'(1)));
  p_idle_rest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !trig) |=> !active);
  p_strobe_needs_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |-> $past(active));
endmodule

// File: tb/test_hb_decim_core.sv
`timescale 1ns/1ps
module test_hb_decim_core;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_we = 1'b0;
  logic [7:0]         cfg_addr = '0;
  logic [31:0]        cfg_data = '0;
  logic signed [16:0] smp_in = '0;
  logic               smp_vld = 1'b0;
  logic signed [17:0] smp_out;
  logic               out_vld;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done_run = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_decim_core i_hb_decim_core (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .smp_i(smp_in), .smp_vld_i(smp_vld),
    .smp_o(smp_out), .smp_vld_o(out_vld)
  );

  localparam int NV = 24;
  localparam int VEC [NV] = '{0, 0, 30000, 0, 0, 0, 0, 0, 0, 0, -20000, 0,
                              0, 0, 5000, 5000, 5000, 5000, 5000, 5000,
                              -65536, 65535, -65536, 65535};
  localparam int BASE_COEF [8] = '{20628, -6282, 3135, -1681, 873, -412, 165, -49};

  // bench model
  longint m_ev [16];
  longint m_od [16];
  longint m_c  [8];
  bit     m_odd = 0;
  longint exp_val [512];
  int     exp_due [512];
  int     head = 0, tail = 0;

  function automatic longint sat18(longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic longint model_out();
    longint acc;
    acc = m_ev[15] * 32768;
    for (int k = 0; k < 8; k++) acc += (m_od[15-k] + m_od[k]) * m_c[k];
    return sat18((acc + 32768) >>> 16);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin m_ev[i] = 0; m_od[i] = 0; end
    m_odd = 0;
  endtask

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(int x, int gap);
    @(negedge clk);
    smp_in = 17'(x); smp_vld = 1'b1;
    if (!m_odd) begin
      for (int i = 15; i > 0; i--) m_ev[i] = m_ev[i-1];
      m_ev[0] = x;
    end else begin
      for (int i = 15; i > 0; i--) m_od[i] = m_od[i-1];
      m_od[0] = x;
      exp_val[tail] = model_out();
      exp_due[tail] = cyc + 9;  // stored at next edge, result 8 edges later (R7)
      tail++;
    end
    m_odd = !m_odd;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic drain();
    repeat (14) @(negedge clk);
  endtask

  function automatic logic [31:0] tword(bit stb, bit ac, bit ld, bit dn,
                                        int ev, int oa, int ob, int cf);
    return {12'hA5C, stb, ac, ld, dn, 4'(ev), 4'(oa), 4'(ob), 4'(cf)};
  endfunction

  // output monitor: timing and value of every result (R6, R7, R8, R10)
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      if (head != tail && exp_due[head] == cyc) begin
        check("R7 strobe", out_vld, 1);
        check("R6/R8 value", smp_out, exp_val[head]);
        head++;
      end else if (out_vld) begin
        check("R10 unexpected strobe", out_vld, 0);
      end
    end
  end

  task automatic finish_run();
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    model_clear();
    for (int k = 0; k < 8; k++) m_c[k] = BASE_COEF[k];
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset smp_o", smp_out, 0);
    check("R1 reset vld", out_vld, 0);
    rst_n = 1'b1;
    // R2: coefficients with junk in upper bits
    for (int k = 0; k < 8; k++) cfg_wr(124, {14'h2AB5, 18'(BASE_COEF[k])});
    // R3: table filled phase 8 down to phase 0
    cfg_wr(125, tword(1, 1, 0, 1, 15, 15, 0, 0));
    for (int p = 7; p >= 2; p--) cfg_wr(125, tword(0, 1, 0, 0, 15, 7 + p, 8 - p, 8 - p));
    cfg_wr(125, tword(0, 0, 1, 0, 15, 8, 7, 7));
    cfg_wr(125, tword(0, 0, 0, 0, 15, 8, 7, 7));
    // R9: writes to other addresses must change nothing
    cfg_wr(126, 32'hFFFF_FFFF);
    cfg_wr(123, 32'h0000_0000);
    cfg_wr(0,   32'h1234_5678);
    check("R10 idle no strobe", out_vld, 0);

    // R8: back-to-back, trigger coincides with done phase
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NV; i++) send(VEC[i], 4);
    drain();
    // R10: wider spacing, sequencer rests at phase 0
    for (int i = 0; i < NV; i++) send(VEC[NV-1-i], 7);
    drain();

    // R2: pointer wrapped, reload with full-scale coefficients
    for (int k = 0; k < 8; k++) begin
      cfg_wr(124, 32'hFFFC_0000 | 32'h0001_FFFF);
      m_c[k] = 131071;
    end
    // R6: positive then negative saturation
    for (int i = 0; i < 32; i++) send(65535, 4);
    for (int i = 0; i < 32; i++) send(-65536, 4);
    drain();
    check("R6 all results seen", head, tail);

    // R1: reset mid-stream clears history
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    check("R1 reset smp_o mid", smp_out, 0);
    check("R1 reset vld mid", out_vld, 0);
    rst_n = 1'b1;
    send(3, 4);
    send(5, 4);  // odd[15]+odd[0]=5 -> (5*131071+32768)>>>16 = 10
    drain();
    check("R1 cleared history", exp_val[tail-1], 10);
    check("R4 all results seen", head, tail);
    finish_run();
  end
endmodule